// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the device end of a three-wire serial link: a chip-enable, a serial clock and one bidirectional data line. All three wires are sampled by a fast system clock through short synchronizer chains. Edges of the serial clock are detected from the synchronized copies. A transfer opens with a command byte. The command either writes data bytes into the addressed register or streams register contents back out on the data line.

The block holds a 31-byte scratch RAM. It reaches a separate bank of timekeeping registers through a plain address, data and write-strobe port. The read data of that bank is returned combinationally. Both single-byte and burst transfers are supported. The data line is modelled as an output value with a separate output enable, so the pad can be placed outside the block.

Top module: `serial_reg_slave`

## Requirements
- R1: The command byte arrives LSB first, one bit captured per rising serial clock edge. In bit order 7..0 it is: write-enable (bit 7), space select (bit 6, 0 = timekeeping, 1 = RAM), address (bits 5..1) and direction (bit 0, 0 = write, 1 = read).
- R2: In a write, the eight data bits are captured LSB first on rising edges. The byte is committed to the addressed register when its eighth bit is taken.
- R3: When command bit 7 is 0, no RAM byte changes and the timekeeping write strobe never pulses.
- R4: In a read, bit 0 of the addressed register is driven on the first falling edge after the eighth command bit. Each later falling edge drives the next bit, LSB first.
- R5: The output enable goes low after every rising serial clock edge, and stays low while chip-enable is low.
- R6: In a single-byte write, serial clocks after the eighth data bit change nothing.
- R7: In a single-byte read, serial clocks after the first byte resend the same register for as long as chip-enable stays high.
- R8: Address 31 selects burst mode. The transfer starts at address 0 and advances by one per byte. It wraps to 0 after the last stored register: address 30 for RAM and address 8 for the timekeeping space.
- R9: In a RAM burst write, every fully received byte is kept. A byte cut short by chip-enable falling is discarded.
- R10: The timekeeping space stores addresses 0..8. A write there pulses the strobe once, carrying the address and data. A read of addresses 9..30 returns 0x00, and a write to them produces no strobe.
- R11: Lowering chip-enable ends a transfer at any bit. The next transfer starts again with a fresh command byte.
- R12: After reset the output enable and the write strobe are low, and every RAM byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_in | input | 1 | Chip-enable from the link |
| sclk_in | input | 1 | Serial clock from the link |
| dio_in | input | 1 | Data line as seen at the pad |
| dio_out | output | 1 | Data value to drive onto the line |
| dio_oe | output | 1 | Drive enable for the data line |
| tk_addr | output | 5 | Timekeeping register address |
| tk_wdata | output | 8 | Timekeeping write data |
| tk_we | output | 1 | One-cycle timekeeping write strobe |
| tk_rdata | input | 8 | Timekeeping read data for tk_addr |

## Verification
The bench builds the block with its defaults: two synchronizer stages, 31 RAM bytes and 9 timekeeping registers. It holds each serial clock phase for eight system clocks, which leaves room for the synchronizer delay. With these values, a 33-byte RAM burst read crosses the 30-to-0 wrap, and a 10-byte timekeeping burst crosses the 8-to-0 wrap. The external read data returns 0xEE for addresses 9 and above, so the forced 0x00 on unused reads is visible at the port.

// File: rtl/serial_reg_slave.sv
module serial_reg_slave #(
  parameter int SYNC_LEN  = 2,
  parameter int RAM_BYTES = 31,
  parameter int TK_REGS   = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_in,
  input  logic       sclk_in,
  input  logic       dio_in,
  output logic       dio_out,
  output logic       dio_oe,
  output logic [4:0] tk_addr,
  output logic [7:0] tk_wdata,
  output logic       tk_we,
  input  logic [7:0] tk_rdata
);
  localparam logic [4:0] RAM_LAST = 5'(RAM_BYTES - 1);
  localparam logic [4:0] TK_LAST  = 5'(TK_REGS - 1);

  logic [SYNC_LEN-1:0] ce_q, sclk_q, dio_q;
  logic ce_s, sclk_s, dio_s, sclk_d;
  logic rise, fall;

  logic       cmd_done, wr_stop;
  logic [2:0] bitcnt;
  logic [7:0] sh, cmd, osh;
  logic [4:0] addr;
  logic [7:0] ram [RAM_BYTES];

  assign ce_s   = ce_q[SYNC_LEN-1];
  assign sclk_s = sclk_q[SYNC_LEN-1];
  assign dio_s  = dio_q[SYNC_LEN-1];
  assign rise   = ce_s & sclk_s & ~sclk_d;
  assign fall   = ce_s & ~sclk_s & sclk_d;

  wire [7:0] byte_in  = {dio_s, sh[7:1]};
  wire       is_ram   = cmd[6];
  wire       is_rd    = cmd[0];
  wire       burst    = &cmd[5:1];
  wire [4:0] last_adr = is_ram ? RAM_LAST : TK_LAST;
  wire [4:0] next_adr = (addr == last_adr) ? 5'd0 : addr + 5'd1;
  wire       wr_fire  = rise & cmd_done & ~is_rd & cmd[7] & ~wr_stop & (bitcnt == 3'd7);
  wire       ram_ok   = int'(addr) < RAM_BYTES;
  wire       tk_ok    = int'(addr) < TK_REGS;
  wire [7:0] rd_byte  = is_ram ? (ram_ok ? ram[addr] : 8'h00)
                               : (tk_ok ? tk_rdata : 8'h00);

  assign tk_addr  = addr;
  assign tk_wdata = byte_in;
  assign tk_we    = wr_fire & ~is_ram & tk_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= '0;
      sclk_q <= '0;
      dio_q  <= '0;
      sclk_d <= 1'b0;
    end else begin
      ce_q   <= {ce_q[SYNC_LEN-2:0], ce_in};
      sclk_q <= {sclk_q[SYNC_LEN-2:0], sclk_in};
      dio_q  <= {dio_q[SYNC_LEN-2:0], dio_in};
      sclk_d <= sclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_done <= 1'b0;
      wr_stop  <= 1'b0;
      bitcnt   <= '0;
      sh       <= '0;
      cmd      <= '0;
      osh      <= '0;
      addr     <= '0;
      dio_out  <= 1'b0;
      dio_oe   <= 1'b0;
    end else if (!ce_s) begin
      cmd_done <= 1'b0;
      wr_stop  <= 1'b0;
      bitcnt   <= '0;
      dio_oe   <= 1'b0;
    end else if (rise) begin
      bitcnt <= bitcnt + 3'd1;
      if (!cmd_done) begin
        sh <= byte_in;
        if (bitcnt == 3'd7) begin
          cmd      <= byte_in;
          cmd_done <= 1'b1;
          addr     <= (&byte_in[5:1]) ? 5'd0 : byte_in[5:1];
        end
      end else if (is_rd) begin
        dio_oe <= 1'b0;
        bitcnt <= bitcnt;
      end else begin
        sh <= byte_in;
        if (bitcnt == 3'd7) begin
          if (burst) addr <= next_adr;
          else wr_stop <= 1'b1;
        end
      end
    end else if (fall && cmd_done && is_rd) begin
      dio_oe <= 1'b1;
      bitcnt <= bitcnt + 3'd1;
      if (bitcnt == 3'd0) begin
        dio_out <= rd_byte[0];
        osh     <= {1'b0, rd_byte[7:1]};
      end else begin
        dio_out <= osh[0];
        osh     <= {1'b0, osh[7:1]};
      end
      if (bitcnt == 3'd7 && burst) addr <= next_adr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_BYTES; i++) ram[i] <= '0;
    end else if (wr_fire && is_ram && ram_ok) begin
      ram[addr] <= byte_in;
    end
  end
endmodule

// File: rtl/serial_reg_slave_chk.sv
module serial_reg_slave_chk #(
  parameter int TK_REGS = 9
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_s,
  input logic       rise,
  input logic       fall,
  input logic       dio_oe,
  input logic       tk_we,
  input logic [4:0] tk_addr,
  input logic       cmd7
);
  assert_float_without_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !dio_oe);
  assert_release_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !dio_oe);
  assert_edges_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));
  assert_drive_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dio_oe) |-> $past(fall));
  assert_strobe_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tk_we |-> (int'(tk_addr) < TK_REGS));
  assert_strobe_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tk_we |-> cmd7);
  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tk_we |=> !tk_we);
endmodule

bind serial_reg_slave serial_reg_slave_chk #(.TK_REGS(TK_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .rise(rise), .fall(fall),
  .dio_oe(dio_oe), .tk_we(tk_we), .tk_addr(tk_addr), .cmd7(cmd[7])
);

// File: tb/sim_serial_reg_slave.sv
module sim_serial_reg_slave;
  logic clk = 0, rst_n = 0;
  logic ce = 0, sclk = 0, dio_drv = 0;
  logic dio_out, dio_oe, tk_we;
  logic [4:0] tk_addr;
  logic [7:0] tk_wdata, tk_rdata;
  int checks = 0, errors = 0;
  int bad_strobe = 0;

  logic [7:0] ram_m [31];
  logic [7:0] tk_m [9];
  logic [7:0] tk_exp [9];

  always #4 clk = ~clk;

  serial_reg_slave u0 (
    .clk(clk), .rst_n(rst_n), .ce_in(ce), .sclk_in(sclk), .dio_in(dio_drv),
    .dio_out(dio_out), .dio_oe(dio_oe), .tk_addr(tk_addr), .tk_wdata(tk_wdata),
    .tk_we(tk_we), .tk_rdata(tk_rdata)
  );

  assign tk_rdata = (tk_addr < 5'd9) ? tk_m[tk_addr] : 8'hEE;

  always @(posedge clk) begin
    if (tk_we) begin
      if (tk_addr < 5'd9) tk_m[tk_addr] <= tk_wdata;
      else bad_strobe++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_cmd(input bit en, input bit ram, input logic [4:0] a, input bit rd);
    return {en, ram, a, rd};
  endfunction

  function automatic logic [7:0] exp_rd(input bit ram, input logic [4:0] a);
    if (ram) return (a < 5'd31) ? ram_m[a] : 8'h00;
    return (a < 5'd9) ? tk_exp[a] : 8'h00;
  endfunction

  task automatic half();
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic begin_x();
    sclk = 0; ce = 1; half();
  endtask

  task automatic end_x();
    ce = 0; dio_drv = 0; half(); half();
  endtask

  task automatic put_bit(input logic b);
    dio_drv = b; half(); sclk = 1; half(); sclk = 0; half();
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_bit(v[i]);
  endtask

  task automatic get_byte(output logic [7:0] v, output bit oe_ok, output bit rel_ok);
    oe_ok = 1; rel_ok = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      v[i] = dio_out;
      if (!dio_oe) oe_ok = 0;
      #1; sclk = 1; half();
      @(negedge clk);
      if (dio_oe) rel_ok = 0;
      #1; sclk = 0; half();
    end
  endtask

  task automatic do_write(input bit ram, input logic [4:0] a, input logic [7:0] d);
    begin_x(); put_byte(mk_cmd(1, ram, a, 0)); put_byte(d); end_x();
    if (ram && a < 5'd31) ram_m[a] = d;
    if (!ram && a < 5'd9) tk_exp[a] = d;
  endtask

  task automatic check_read(input bit ram, input logic [4:0] a, input string req);
    logic [7:0] v; bit ok1, ok2;
    begin_x(); put_byte(mk_cmd(1, ram, a, 1)); get_byte(v, ok1, ok2); end_x();
    chk(req, v, exp_rd(ram, a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v; bit ok1, ok2;
    void'($urandom(32'd1302));
    for (int i = 0; i < 31; i++) ram_m[i] = 8'h00;
    for (int i = 0; i < 9; i++) begin tk_m[i] = 8'h10 + 8'(i); tk_exp[i] = 8'h10 + 8'(i); end
    repeat (5) @(posedge clk); #1;
    chk("R12 oe after reset", dio_oe, 0);
    chk("R12 strobe after reset", tk_we, 0);
    rst_n = 1; half();
    check_read(1, 5'd5, "R12 ram cleared");

    // R2 / R6: single write, then extra clocks with ones
    begin_x(); put_byte(mk_cmd(1, 1, 5'd3, 0)); put_byte(8'hA5); put_byte(8'hFF); end_x();
    ram_m[3] = 8'hA5;
    check_read(1, 5'd3, "R2 single write");
    check_read(1, 5'd4, "R6 extra clocks ignored");

    // R4 / R5 / R7: repeated single read
    begin_x(); put_byte(mk_cmd(1, 1, 5'd3, 1));
    for (int k = 0; k < 3; k++) begin
      get_byte(v, ok1, ok2);
      chk("R7 repeat byte", v, 8'hA5);
      chk("R4 driven after fall", ok1, 1);
      chk("R5 released on rise", ok2, 1);
    end
    end_x();
    @(negedge clk); chk("R5 float with ce low", dio_oe, 0);

    // R3: write-enable clear
    begin_x(); put_byte(mk_cmd(0, 1, 5'd3, 0)); put_byte(8'h5A); end_x();
    check_read(1, 5'd3, "R3 ram write blocked");
    begin_x(); put_byte(mk_cmd(0, 0, 5'd1, 0)); put_byte(8'h99); end_x();
    chk("R3 tk write blocked", tk_m[1], tk_exp[1]);

    // R10: timekeeping space
    do_write(0, 5'd2, 8'h37);
    chk("R10 tk write", tk_m[2], 8'h37);
    check_read(0, 5'd2, "R10 tk read");
    check_read(0, 5'd12, "R10 unused read zero");
    do_write(0, 5'd12, 8'h44);
    chk("R10 unused write no strobe", bad_strobe, 0);

    // R8: RAM burst write and wrapping read
    begin_x(); put_byte(mk_cmd(1, 1, 5'd31, 0));
    for (int i = 0; i < 31; i++) begin
      logic [7:0] d = 8'($urandom);
      put_byte(d); ram_m[i] = d;
    end
    end_x();
    begin_x(); put_byte(mk_cmd(1, 1, 5'd31, 1));
    for (int i = 0; i < 33; i++) begin
      get_byte(v, ok1, ok2);
      chk("R8 ram burst read", v, ram_m[i % 31]);
    end
    end_x();

    // R8: timekeeping burst read wraps after 8
    begin_x(); put_byte(mk_cmd(1, 0, 5'd31, 1));
    for (int i = 0; i < 10; i++) begin
      get_byte(v, ok1, ok2);
      chk("R8 tk burst read", v, tk_exp[i % 9]);
    end
    end_x();

    // R9: partial burst write
    begin_x(); put_byte(mk_cmd(1, 1, 5'd31, 0));
    put_byte(8'hC1); put_byte(8'hC2);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    end_x();
    ram_m[0] = 8'hC1; ram_m[1] = 8'hC2;
    check_read(1, 5'd0, "R9 full byte 0 kept");
    check_read(1, 5'd1, "R9 full byte 1 kept");
    check_read(1, 5'd2, "R9 partial byte dropped");

    // R11: abort mid-byte, then fresh command
    begin_x(); put_byte(mk_cmd(1, 1, 5'd7, 0));
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    end_x();
    check_read(1, 5'd7, "R11 abort keeps old");

    // R1 / R4: random mix
    for (int n = 0; n < 40; n++) begin
      bit ram = 1'($urandom);
      logic [4:0] a = 5'($urandom_range(0, 30));
      if ($urandom_range(0, 1)) do_write(ram, a, 8'($urandom));
      check_read(ram, a, "R1 random command");
      if (!ram && a < 5'd9) chk("R10 random tk store", tk_m[a], tk_exp[a]);
    end
    chk("R10 no stray strobe", bad_strobe, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule